// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block gathers eight level-sensitive interrupt lines from peripherals and turns them into one interrupt request. The sources, in index order 0 to 7, are: flash, AES, IDE, peripheral error, USB0, USB1, button and module. Every source has an enable bit. Software changes an enable bit by writing a command word in which each source has its own clear bit and its own set bit. No read-modify-write is needed, and other sources are not disturbed.

Two readback words are available. The mask word shows the enable bits. The status word shows the raw pending levels, whatever the mask, together with two extra level flags: button pressed and module removed. The interrupt output is registered. It is the OR of all pending sources whose enable bit is set. The peripherals clear their own lines, and this block only samples them. The block does no prioritisation and no vectoring.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mask_rd_o`, `stat_rd_o` and `irq_o` are all zero.
- R2: A write (`wr_en_i` high) with bit 13+2*i set and bit 12+2*i clear sets the enable bit of source i (i = 0 flash, 1 AES, 2 IDE, 3 peripheral error, 4 USB0, 5 USB1, 6 button, 7 module). The enable bit is visible at `mask_rd_o` bit 6+i after the next clock edge.
- R3: A write with bit 12+2*i set and bit 13+2*i clear clears the enable bit of source i after the next clock edge.
- R4: A write with both bit 12+2*i and bit 13+2*i set leaves the enable bit of source i unchanged.
- R5: A single write may carry commands for several sources. Each command acts only on its own source, and sources without a command keep their enable bit.
- R6: A write that sets none of bits 12..27 changes no enable bit, whatever its other bits hold. A cycle with `wr_en_i` low also changes no enable bit.
- R7: `stat_rd_o` bit 6+i shows the level of `src_i[i]` from the previous cycle, regardless of the mask. The bits of `mask_rd_o` and `stat_rd_o` that no requirement assigns read as zero.
- R8: `stat_rd_o` bit 24 shows the level of `btn_lvl_i` and bit 25 shows the level of `mod_gone_i`, both from the previous cycle.
- R9: `irq_o` is high in a cycle exactly when, in the previous cycle, at least one source was high with its enable bit set. A pending source whose enable bit is clear never raises `irq_o`.
- R10: `irq_o` falls one cycle after the last enabled pending source drops, or one cycle after the clear command for that source takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 8 | Level interrupt lines, index 0 flash through 7 module |
| btn_lvl_i | input | 1 | Button-pressed level flag |
| mod_gone_i | input | 1 | Module-removed level flag |
| wr_en_i | input | 1 | Mask command write strobe |
| wr_data_i | input | 32 | Mask command word (clear/set pairs at bits 12..27) |
| mask_rd_o | output | 32 | Enable bits at positions 6..13 |
| stat_rd_o | output | 32 | Pending levels at 6..13, button at 24, module at 25 |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The first pattern walks a set command across all eight sources while the matching source line is high. It separates correct pair decoding from an off-by-one in the set or clear positions or in the readback positions. Later patterns raise source lines while their enable bits are clear, to tell the raw status path apart from the masked interrupt path. Words with both bits of a pair set, words that mix set, clear and no-op pairs, and words whose only ones lie outside the command field show whether the pairs are independent and whether a contradictory or empty command leaves the mask alone. Clearing the last enabled source while others are still pending but masked checks that the request falls exactly one cycle later.

// File: rtl/imc_pkg.sv
package imc_pkg;
  // Default geometry of the controller.
  localparam int IMC_NUM_SRC  = 8;   // interrupt sources
  localparam int IMC_DATA_W   = 32;  // register word width
  localparam int IMC_RD_BASE  = 6;   // first readback bit of source 0
  localparam int IMC_CMD_BASE = 12;  // clear bit of source 0; set is +1
  localparam int IMC_BTN_BIT  = 24;  // button-pressed flag in status
  localparam int IMC_MOD_BIT  = 25;  // module-removed flag in status

  // Command word: one clear/set pair per source.
  function automatic logic [IMC_DATA_W-1:0] cmd_field_mask(input int nsrc, input int base);
    logic [IMC_DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < 2 * nsrc; k++) m[base + k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/imc_mask_bank.sv
module imc_mask_bank #(
  parameter int NUM_SRC = imc_pkg::IMC_NUM_SRC,
  localparam int CMD_W  = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CMD_W-1:0]   cmd,      // pair i: [2i] clear, [2i+1] set
  output logic [NUM_SRC-1:0] mask_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic clr_c, set_c;
    assign clr_c = wr_en & cmd[2*i];
    assign set_c = wr_en & cmd[2*i+1];

    always_ff @(posedge clk) begin
      if (rst)                mask_q[i] <= 1'b0;
      else if (set_c ^ clr_c) mask_q[i] <= set_c;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
      (wr_en && cmd[2*i+1] && !cmd[2*i]) |=> mask_q[i]);          // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (wr_en && cmd[2*i] && !cmd[2*i+1]) |=> !mask_q[i]);         // R3
    AST_BOTH_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && cmd[2*i] && cmd[2*i+1]) |=> $stable(mask_q[i]));  // R4
    AST_PAIR_IDLE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !cmd[2*i] && !cmd[2*i+1]) |=> $stable(mask_q[i])); // R5
  end
endmodule

// File: rtl/imc_sampler.sv
module imc_sampler #(
  parameter int NUM_SRC = imc_pkg::IMC_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic               btn,
  input  logic               mod,
  output logic [NUM_SRC-1:0] pend_q,
  output logic               btn_q,
  output logic               mod_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      btn_q  <= 1'b0;
      mod_q  <= 1'b0;
    end else begin
      pend_q <= src;
      btn_q  <= btn;
      mod_q  <= mod;
    end
  end

  AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pend_q == $past(src)));                      // R7
  AST_FLAGS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (btn_q == $past(btn) && mod_q == $past(mod))); // R8
endmodule

// File: rtl/imc_readback.sv
module imc_readback #(
  parameter int NUM_SRC = imc_pkg::IMC_NUM_SRC,
  parameter int DATA_W  = imc_pkg::IMC_DATA_W,
  parameter int RD_BASE = imc_pkg::IMC_RD_BASE,
  parameter int BTN_BIT = imc_pkg::IMC_BTN_BIT,
  parameter int MOD_BIT = imc_pkg::IMC_MOD_BIT
) (
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] pend_q,
  input  logic               btn_q,
  input  logic               mod_q,
  output logic [DATA_W-1:0]  mask_word,
  output logic [DATA_W-1:0]  stat_word
);
  always_comb begin
    mask_word = '0;
    stat_word = '0;
    mask_word[RD_BASE +: NUM_SRC] = mask_q;
    stat_word[RD_BASE +: NUM_SRC] = pend_q;
    stat_word[BTN_BIT]            = btn_q;
    stat_word[MOD_BIT]            = mod_q;
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int NUM_SRC  = imc_pkg::IMC_NUM_SRC,
  parameter int DATA_W   = imc_pkg::IMC_DATA_W,
  parameter int RD_BASE  = imc_pkg::IMC_RD_BASE,
  parameter int CMD_BASE = imc_pkg::IMC_CMD_BASE,
  parameter int BTN_BIT  = imc_pkg::IMC_BTN_BIT,
  parameter int MOD_BIT  = imc_pkg::IMC_MOD_BIT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               btn_lvl_i,
  input  logic               mod_gone_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  mask_rd_o,
  output logic [DATA_W-1:0]  stat_rd_o,
  output logic               irq_o
);
  localparam int CMD_W = 2 * NUM_SRC;
  localparam logic [DATA_W-1:0] CMD_MASK = imc_pkg::cmd_field_mask(NUM_SRC, CMD_BASE);

  logic [NUM_SRC-1:0] mask_q, pend_q;
  logic               btn_q, mod_q, irq_q;

  imc_mask_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en_i),
    .cmd(wr_data_i[CMD_BASE +: CMD_W]), .mask_q(mask_q)
  );

  imc_sampler #(.NUM_SRC(NUM_SRC)) u_samp (
    .clk(clk), .rst(rst), .src(src_i), .btn(btn_lvl_i), .mod(mod_gone_i),
    .pend_q(pend_q), .btn_q(btn_q), .mod_q(mod_q)
  );

  imc_readback #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .RD_BASE(RD_BASE),
    .BTN_BIT(BTN_BIT), .MOD_BIT(MOD_BIT)
  ) u_rb (
    .mask_q(mask_q), .pend_q(pend_q), .btn_q(btn_q), .mod_q(mod_q),
    .mask_word(mask_rd_o), .stat_word(stat_rd_o)
  );

  // Combined request: masked OR of the live lines, one register deep.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(src_i & mask_q);
  end
  assign irq_o = irq_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && mask_rd_o == '0 && stat_rd_o == '0)); // R1
  AST_NO_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i || (wr_data_i & CMD_MASK) == '0) |=> $stable(mask_rd_o)); // R6
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == |($past(src_i) & $past(mask_rd_o[RD_BASE +: NUM_SRC])))); // R9
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    ((src_i & mask_q) == '0) |=> !irq_o);                          // R10
endmodule

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic [N-1:0] src;
  logic        btn, mod, wr_en;
  logic [31:0] wr_data;
  logic [31:0] mask_rd, stat_rd;
  logic        irq;

  always #10 clk = ~clk; // 50 MHz

  irq_mask_ctrl i_irq_mask_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .btn_lvl_i(btn), .mod_gone_i(mod),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .mask_rd_o(mask_rd), .stat_rd_o(stat_rd), .irq_o(irq)
  );

  typedef struct {
    logic [31:0] mask;
    logic [31:0] stat;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  int     n_chk = 0, n_fail = 0;
  logic [N-1:0] m_mask = '0;
  bit     done = 1'b0;

  // Driver: applies one cycle of stimulus and queues what the next edge must show.
  task automatic step(input logic r, input logic we, input logic [31:0] d,
                      input logic [N-1:0] s, input logic b, input logic md,
                      input string tag);
    exp_t e;
    logic [N-1:0] nm;
    @(negedge clk);
    rst = r; wr_en = we; wr_data = d; src = s; btn = b; mod = md;
    nm = m_mask;
    for (int i = 0; i < N; i++) begin
      if (we && d[13+2*i] && !d[12+2*i]) nm[i] = 1'b1;
      if (we && d[12+2*i] && !d[13+2*i]) nm[i] = 1'b0;
    end
    e.irq  = r ? 1'b0 : |(s & m_mask);
    if (r) nm = '0;
    e.mask = '0; e.stat = '0;
    e.mask[6 +: N] = nm;
    if (!r) begin
      e.stat[6 +: N] = s;
      e.stat[24] = b;
      e.stat[25] = md;
    end
    e.tag  = tag;
    m_mask = nm;
    sb.push_back(e);
  endtask

  // Monitor: compares each queued item just after its edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk += 3;
      if (mask_rd !== e.mask) begin
        n_fail++;
        $display("FAIL %s mask_rd actual=%h expected=%h", e.tag, mask_rd, e.mask);
      end
      if (stat_rd !== e.stat) begin
        n_fail++;
        $display("FAIL %s stat_rd actual=%h expected=%h", e.tag, stat_rd, e.stat);
      end
      if (irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.irq);
      end
    end
  end

  function automatic logic [31:0] setc(input int i); return 32'h1 << (13 + 2*i); endfunction
  function automatic logic [31:0] clrc(input int i); return 32'h1 << (12 + 2*i); endfunction

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; src = '0; btn = 1'b0; mod = 1'b0;
    // R1: reset, even with lines and a set command active
    step(1, 1, 32'h0FFF_F000, 8'hFF, 1, 1, "R1");
    step(1, 0, 0, 8'hFF, 0, 0, "R1");
    step(0, 0, 0, 8'h00, 0, 0, "R1");
    // R7 / R9: pending but masked lines show in status, no request
    step(0, 0, 0, 8'hA5, 0, 0, "R7");
    step(0, 0, 0, 8'h5A, 0, 0, "R9");
    // R8: extra flags
    step(0, 0, 0, 8'h00, 1, 0, "R8");
    step(0, 0, 0, 8'h00, 0, 1, "R8");
    // R2 walking set with its line high; R10 drop between steps
    for (int i = 0; i < N; i++) begin
      step(0, 1, setc(i), 8'h1 << i, 0, 0, "R2");
      step(0, 0, 0, 8'h1 << i, 0, 0, "R9");
      step(0, 0, 0, 8'h00, 0, 0, "R10");
    end
    // R3 walking clear
    for (int i = 0; i < N; i++) begin
      step(0, 1, clrc(i), 8'hFF, 0, 0, "R3");
      step(0, 0, 0, 8'hFF, 0, 0, "R3");
    end
    // R4: both bits of a pair, from 0 and from 1
    step(0, 1, setc(2) | clrc(2), 8'h04, 0, 0, "R4");
    step(0, 1, setc(2), 8'h04, 0, 0, "R2");
    step(0, 1, setc(2) | clrc(2), 8'h04, 0, 0, "R4");
    step(0, 0, 0, 8'h04, 0, 0, "R4");
    // R5: mixed commands in one word
    step(0, 1, setc(0) | setc(5) | clrc(2) | setc(7), 8'h00, 0, 0, "R5");
    step(0, 1, clrc(5) | setc(3) | setc(6) | clrc(6), 8'h00, 0, 0, "R5");
    step(0, 0, 0, 8'h21, 0, 0, "R5");
    // R6: writes with only non-command bits, and strobe low with commands
    step(0, 1, 32'hF000_0FFF, 8'h00, 0, 0, "R6");
    step(0, 0, 32'h0FFF_F000, 8'h00, 0, 0, "R6");
    step(0, 1, 32'hF000_0000, 8'h00, 0, 0, "R6");
    // R10: clear last enabled pending source while masked ones stay high
    step(0, 1, clrc(1) | clrc(4), 8'hFF, 0, 0, "R10");
    step(0, 1, clrc(0) | clrc(3) | clrc(7), 8'hFF, 0, 0, "R10");
    step(0, 0, 0, 8'hFF, 1, 1, "R10");
    step(0, 0, 0, 8'hFF, 0, 0, "R10");
    // R1: reset mid-run clears the mask
    step(0, 1, 32'h0AAA_A000, 8'hFF, 0, 0, "R2");
    step(1, 0, 0, 8'hFF, 1, 1, "R1");
    step(0, 0, 0, 8'hFF, 0, 0, "R1");
    step(0, 0, 0, 8'h00, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule